// File: doc/BRIEF.md
# Double-Buffered Audio Output DMA Engine

This block plays stereo PCM audio out of memory. A host writes a buffer's start address and byte length through a six-word register file. The length write commits the pair into a two-slot queue, so one buffer can play while the next one waits behind it. The engine reads 32-bit words from a simple memory read port. Each word is one frame: two signed 16-bit samples, with the left sample in the upper halfword. Frames go out at a rate set by a programmable clock divider.

A second divider produces a bit clock for the downstream serial converter. An interrupt flag rises when a queued buffer becomes the one being fetched, not when a buffer ends. Software therefore refills one buffer ahead. It acknowledges the flag by writing any value to the status register. When the last queued buffer runs out, the engine stops fetching and the output keeps showing the last frame.

Software sets the sample divider to round(dac_clock / rate) - 1. For a 48,681,812 Hz converter clock at 44.1 kHz this gives 1103. The bit-clock divider is set to min(divider / 66, 16) - 1, which gives 15 for that case.

Top module: `aud_dma_out`

## Requirements
- R1: After reset the irq output, the pcm outputs, pcm_strobe, mem_req_valid and the status word all read 0.
- R2: A write to offset 0 latches the buffer address with its low 3 bits cleared. A write to offset 1 commits the entry {latched address, length with its low 3 bits cleared}. A commit whose masked length is 0 is ignored.
- R3: The status word at offset 3 has busy at bit 30 (a buffer is being fetched) and full at bit 31 (both slots are occupied). A length write while full leaves the queue unchanged.
- R4: Each committed buffer is fetched as length/4 word reads at addr, addr+4, and so on, with buffers taken in commit order. At most one read is outstanding at a time.
- R5: Each fetched word appears once on pcm_left (bits 31:16) and pcm_right (bits 15:0) together with a one-cycle pcm_strobe. The pcm outputs hold their value whenever pcm_strobe is low.
- R6: While enabled, frames leave on ticks of a divider that fires every (offset 4 value + 1) clocks. The spacing between any two frames in one enabled run is a multiple of that period.
- R7: While enabled, bit_clk toggles every (offset 5 value + 1) clocks. While disabled it holds its level.
- R8: irq is set when a buffer becomes the active one: on a commit into an empty queue, or when a waiting buffer is promoted. Any write to offset 3 clears it, and a set in the same cycle wins. irq also reads at status bit 0.
- R9: Control bit 0 at offset 2 enables fetching and output. While it is 0, no read is issued and no frame leaves. The queue keeps its contents, and playback resumes where it stopped when the bit is set again.
- R10: Once the last queued buffer has been fetched, busy drops, no further reads or strobes occur, and the pcm outputs keep the last frame.
- R11: Offsets 0, 1, 2, 4 and 5 read back the last written value after masking to the field width. Offsets 6 and 7 read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 3 | Register word offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_sel (combinational) |
| mem_req_valid | output | 1 | Word read request valid |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_addr | output | AW | Byte address of the word read |
| mem_rsp_valid | input | 1 | Read data return valid |
| mem_rsp_data | input | 32 | Returned word (one frame) |
| pcm_strobe | output | 1 | One-cycle pulse with each new frame |
| pcm_left | output | 16 | Left sample |
| pcm_right | output | 16 | Right sample |
| bit_clk | output | 1 | Divided bit clock for the converter |
| irq | output | 1 | Buffer-started interrupt flag |

## Verification
The bench targets four corner cases.

- A length write while both slots are busy must change nothing. A design that accepted it would fetch an extra buffer of words, and the address stream would no longer match the reference.
- A commit whose length masks to zero must be ignored. A design that queued it would raise busy or full, or would hang waiting for words that are never counted down.
- Promotion at the end of a buffer must raise irq once. A design that raised it at the end of playback would fire one buffer late, and the per-clock irq comparison would show the mismatch.
- Pausing in the middle of a buffer and then resuming must lose and repeat no frame. After the last buffer, the outputs must freeze on the final word rather than replaying stale data.

// File: rtl/aud_dma_pkg.sv
package aud_dma_pkg;

   typedef enum logic [2:0] {
      SEL_ADDR = 3'd0,
      SEL_LEN  = 3'd1,
      SEL_CTRL = 3'd2,
      SEL_STAT = 3'd3,
      SEL_RATE = 3'd4,
      SEL_BCLK = 3'd5
   } reg_sel_e;

   localparam int STAT_FULL_BIT = 31;
   localparam int STAT_BUSY_BIT = 30;
   localparam int STAT_IRQ_BIT  = 0;
   localparam int CTRL_EN_BIT   = 0;
   localparam int ALIGN_BITS    = 3;
   localparam int WORD_BYTES    = 4;

endpackage

// File: rtl/aud_dma_queue.sv
module aud_dma_queue #(
   parameter int AW = 24,
   parameter int WW = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          push,
   input  logic [AW-1:0] push_addr,
   input  logic [WW-1:0] push_words,
   input  logic          take,
   output logic          act_v,
   output logic          pend_v,
   output logic [AW-1:0] act_addr,
   output logic          promote
);
   import aud_dma_pkg::*;

   typedef struct packed {
      logic [AW-1:0] addr;
      logic [WW-1:0] words;
   } slot_t;

   slot_t act_q, pend_q, incoming;
   logic  act_vq, pend_vq;
   logic  full, accept, last;

   always_comb begin
      incoming = '{addr: push_addr, words: push_words};
      full     = act_vq & pend_vq;
      accept   = push & ~full & (push_words != '0);
      last     = take & (act_q.words == WW'(1));
      promote  = (accept & (~act_vq | (last & ~pend_vq))) | (last & pend_vq);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         act_q   <= '0;
         pend_q  <= '0;
         act_vq  <= 1'b0;
         pend_vq <= 1'b0;
      end else if (last) begin
         if (pend_vq) begin
            act_q   <= pend_q;
            pend_vq <= 1'b0;
         end else if (accept) begin
            act_q   <= incoming;
         end else begin
            act_vq  <= 1'b0;
         end
      end else begin
         if (take) begin
            act_q.addr  <= act_q.addr + AW'(WORD_BYTES);
            act_q.words <= act_q.words - WW'(1);
         end
         if (accept) begin
            if (!act_vq) begin
               act_q  <= incoming;
               act_vq <= 1'b1;
            end else begin
               pend_q  <= incoming;
               pend_vq <= 1'b1;
            end
         end
      end
   end

   assign act_v    = act_vq;
   assign pend_v   = pend_vq;
   assign act_addr = act_q.addr;

endmodule

// File: rtl/aud_dma_pacer.sv
module aud_dma_pacer #(
   parameter int W      = 14,
   parameter bit TOGGLE = 1'b0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         en,
   input  logic [W-1:0] limit,
   output logic         evt
);
   logic [W-1:0] cnt;
   logic         hit;

   assign hit = en & (cnt == limit);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          cnt <= '0;
      else if (!en || hit) cnt <= '0;
      else                 cnt <= cnt + W'(1);
   end

   generate
      if (TOGGLE) begin : g_toggle
         logic lvl;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)   lvl <= 1'b0;
            else if (hit) lvl <= ~lvl;
         end
         assign evt = lvl;
      end else begin : g_pulse
         assign evt = hit;
      end
   endgenerate

endmodule

// File: rtl/aud_dma_fetch.sv
module aud_dma_fetch #(
   parameter int AW = 24
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          en,
   input  logic          act_v,
   input  logic [AW-1:0] act_addr,
   input  logic          tick,
   input  logic          mem_req_ready,
   input  logic          mem_rsp_valid,
   input  logic [31:0]   mem_rsp_data,
   output logic          mem_req_valid,
   output logic [AW-1:0] mem_req_addr,
   output logic          take,
   output logic          pcm_strobe,
   output logic [15:0]   pcm_left,
   output logic [15:0]   pcm_right
);
   logic        outst, hold_v, fire;
   logic [31:0] hold_d;

   assign mem_req_valid = en & act_v & ~outst & ~hold_v;
   assign mem_req_addr  = act_addr;
   assign take          = mem_req_valid & mem_req_ready;
   assign fire          = tick & hold_v;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         outst      <= 1'b0;
         hold_v     <= 1'b0;
         hold_d     <= '0;
         pcm_strobe <= 1'b0;
         pcm_left   <= '0;
         pcm_right  <= '0;
      end else begin
         if (take)               outst <= 1'b1;
         else if (mem_rsp_valid) outst <= 1'b0;

         if (mem_rsp_valid && outst) begin
            hold_v <= 1'b1;
            hold_d <= mem_rsp_data;
         end else if (fire) begin
            hold_v <= 1'b0;
         end

         pcm_strobe <= fire;
         if (fire) begin
            pcm_left  <= hold_d[31:16];
            pcm_right <= hold_d[15:0];
         end
      end
   end

endmodule

// File: rtl/aud_dma_out.sv
module aud_dma_out #(
   parameter int AW     = 24,
   parameter int LW     = 18,
   parameter int RATE_W = 14,
   parameter int BCLK_W = 5
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          reg_we,
   input  logic [2:0]    reg_sel,
   input  logic [31:0]   reg_wdata,
   output logic [31:0]   reg_rdata,
   output logic          mem_req_valid,
   input  logic          mem_req_ready,
   output logic [AW-1:0] mem_req_addr,
   input  logic          mem_rsp_valid,
   input  logic [31:0]   mem_rsp_data,
   output logic          pcm_strobe,
   output logic [15:0]   pcm_left,
   output logic [15:0]   pcm_right,
   output logic          bit_clk,
   output logic          irq
);
   import aud_dma_pkg::*;

   localparam int WW = LW - 2;

   generate
      if (AW < 8 || AW > 32) begin : g_bad_aw
         $error("aud_dma_out: AW must lie in 8..32");
      end
      if (LW < 4 || LW > 32) begin : g_bad_lw
         $error("aud_dma_out: LW must lie in 4..32");
      end
      if (RATE_W < 1 || RATE_W > 32 || BCLK_W < 1 || BCLK_W > 32) begin : g_bad_div
         $error("aud_dma_out: divider widths must lie in 1..32");
      end
   endgenerate

   logic [AW-1:0]     addr_hold;
   logic [LW-1:0]     len_reg;
   logic              en_q;
   logic [RATE_W-1:0] rate_q;
   logic [BCLK_W-1:0] bclk_q;
   logic              irq_q;

   logic wr_addr, wr_len, wr_ctrl, wr_stat, wr_rate, wr_bclk;
   logic q_act_v, q_pend_v, q_promote, take, tick;
   logic [AW-1:0] q_act_addr;
   logic [WW-1:0] push_words;
   logic          unused_wdata;

   assign wr_addr = reg_we & (reg_sel == SEL_ADDR);
   assign wr_len  = reg_we & (reg_sel == SEL_LEN);
   assign wr_ctrl = reg_we & (reg_sel == SEL_CTRL);
   assign wr_stat = reg_we & (reg_sel == SEL_STAT);
   assign wr_rate = reg_we & (reg_sel == SEL_RATE);
   assign wr_bclk = reg_we & (reg_sel == SEL_BCLK);

   assign push_words   = {reg_wdata[LW-1:ALIGN_BITS], 1'b0};
   assign unused_wdata = ^reg_wdata;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         addr_hold <= '0;
         len_reg   <= '0;
         en_q      <= 1'b0;
         rate_q    <= '0;
         bclk_q    <= '0;
         irq_q     <= 1'b0;
      end else begin
         if (wr_addr) addr_hold <= {reg_wdata[AW-1:ALIGN_BITS], {ALIGN_BITS{1'b0}}};
         if (wr_len)  len_reg   <= {reg_wdata[LW-1:ALIGN_BITS], {ALIGN_BITS{1'b0}}};
         if (wr_ctrl) en_q      <= reg_wdata[CTRL_EN_BIT];
         if (wr_rate) rate_q    <= reg_wdata[RATE_W-1:0];
         if (wr_bclk) bclk_q    <= reg_wdata[BCLK_W-1:0];
         if (q_promote)    irq_q <= 1'b1;
         else if (wr_stat) irq_q <= 1'b0;
      end
   end

   always_comb begin
      reg_rdata = '0;
      case (reg_sel)
         SEL_ADDR: reg_rdata[AW-1:0]     = addr_hold;
         SEL_LEN:  reg_rdata[LW-1:0]     = len_reg;
         SEL_CTRL: reg_rdata[CTRL_EN_BIT] = en_q;
         SEL_STAT: begin
            reg_rdata[STAT_FULL_BIT] = q_act_v & q_pend_v;
            reg_rdata[STAT_BUSY_BIT] = q_act_v;
            reg_rdata[STAT_IRQ_BIT]  = irq_q;
         end
         SEL_RATE: reg_rdata[RATE_W-1:0] = rate_q;
         SEL_BCLK: reg_rdata[BCLK_W-1:0] = bclk_q;
         default:  reg_rdata = '0;
      endcase
   end

   aud_dma_queue #(.AW(AW), .WW(WW)) u_queue (
      .clk        (clk),
      .rst_n      (rst_n),
      .push       (wr_len),
      .push_addr  (addr_hold),
      .push_words (push_words),
      .take       (take),
      .act_v      (q_act_v),
      .pend_v     (q_pend_v),
      .act_addr   (q_act_addr),
      .promote    (q_promote)
   );

   aud_dma_pacer #(.W(RATE_W), .TOGGLE(1'b0)) u_rate (
      .clk   (clk),
      .rst_n (rst_n),
      .en    (en_q),
      .limit (rate_q),
      .evt   (tick)
   );

   aud_dma_pacer #(.W(BCLK_W), .TOGGLE(1'b1)) u_bclk (
      .clk   (clk),
      .rst_n (rst_n),
      .en    (en_q),
      .limit (bclk_q),
      .evt   (bit_clk)
   );

   aud_dma_fetch #(.AW(AW)) u_fetch (
      .clk           (clk),
      .rst_n         (rst_n),
      .en            (en_q),
      .act_v         (q_act_v),
      .act_addr      (q_act_addr),
      .tick          (tick),
      .mem_req_ready (mem_req_ready),
      .mem_rsp_valid (mem_rsp_valid),
      .mem_rsp_data  (mem_rsp_data),
      .mem_req_valid (mem_req_valid),
      .mem_req_addr  (mem_req_addr),
      .take          (take),
      .pcm_strobe    (pcm_strobe),
      .pcm_left      (pcm_left),
      .pcm_right     (pcm_right)
   );

   assign irq = irq_q;

endmodule

// File: rtl/aud_dma_out_chk.sv
module aud_dma_out_chk #(
   parameter int AW = 24
) (
   input logic          clk,
   input logic          rst_n,
   input logic          en_q,
   input logic          mem_req_valid,
   input logic [AW-1:0] mem_req_addr,
   input logic          pcm_strobe,
   input logic [15:0]   pcm_left,
   input logic [15:0]   pcm_right,
   input logic          act_v,
   input logic          pend_v,
   input logic          promote,
   input logic          irq
);
   logic unused_addr_hi;
   assign unused_addr_hi = ^mem_req_addr;

   // R9
   no_req_when_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !en_q |-> !mem_req_valid);

   // R4
   word_aligned_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req_valid |-> (mem_req_addr[1:0] == 2'b00));

   // R3
   full_needs_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pend_v |-> act_v);

   // R8
   irq_rise_on_promote_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq) |-> $past(promote));

   // R5
   pcm_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !pcm_strobe |-> ($stable(pcm_left) && $stable(pcm_right)));

   // R9
   strobe_needs_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pcm_strobe |-> $past(en_q));

   // R10
   idle_no_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !act_v |-> !mem_req_valid);

endmodule

bind aud_dma_out aud_dma_out_chk #(.AW(AW)) u_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .en_q          (en_q),
   .mem_req_valid (mem_req_valid),
   .mem_req_addr  (mem_req_addr),
   .pcm_strobe    (pcm_strobe),
   .pcm_left      (pcm_left),
   .pcm_right     (pcm_right),
   .act_v         (q_act_v),
   .pend_v        (q_pend_v),
   .promote       (q_promote),
   .irq           (irq)
);

// File: tb/aud_dma_out_tb.sv
module aud_dma_out_tb;
   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_we = 1'b0;
   logic [2:0]  reg_sel = '0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic        mem_req_valid;
   logic        mem_req_ready = 1'b0;
   logic [23:0] mem_req_addr;
   logic        mem_rsp_valid = 1'b0;
   logic [31:0] mem_rsp_data = '0;
   logic        pcm_strobe;
   logic [15:0] pcm_left, pcm_right;
   logic        bit_clk;
   logic        irq;

   aud_dma_out u_dut (
      .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_sel(reg_sel),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
      .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
      .mem_req_addr(mem_req_addr), .mem_rsp_valid(mem_rsp_valid),
      .mem_rsp_data(mem_rsp_data), .pcm_strobe(pcm_strobe),
      .pcm_left(pcm_left), .pcm_right(pcm_right), .bit_clk(bit_clk), .irq(irq)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   int errors = 0;
   int checks = 0;
   int cyc = 0;
   bit done = 0;

   task automatic chk(input bit ok, input string req, input string what,
                      input longint act, input longint exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   function automatic logic [31:0] memf(input logic [31:0] a);
      return {a[15:0] ^ 16'h5A3C, ~a[15:0]};
   endfunction

   // reference model state
   int          m_bufs[$];
   logic [31:0] exp_addr[$];
   logic [31:0] exp_frm[$];
   bit          m_irq = 0;
   int          m_rate = 0, m_bclk = 0;
   logic [31:0] m_hold = 0;
   bit          pend_rsp = 0;
   logic [31:0] pend_data = 0;
   int          last_strobe = -1, last_tog = -1, tog_count = 0;
   logic        prev_bclk = 0;
   int          frames_seen = 0;

   always @(negedge clk) begin
      if (rst_n) begin
         bit hs, promote;
         int nb;
         cyc++;
         // compare DUT against model
         chk(irq === m_irq, "R8", "irq", irq, m_irq);
         if (mem_req_valid)
            chk(exp_addr.size() > 0 && {8'h0, mem_req_addr} == exp_addr[0], "R4",
                "fetch address", mem_req_addr, exp_addr.size() > 0 ? exp_addr[0] : 32'hFFFFFFFF);
         if (pcm_strobe) begin
            logic [31:0] e;
            e = exp_frm.size() > 0 ? exp_frm.pop_front() : 32'hDEADBEEF;
            chk({pcm_left, pcm_right} == e, "R5", "frame", {pcm_left, pcm_right}, e);
            if (last_strobe >= 0)
               chk((cyc - last_strobe) % (m_rate + 1) == 0, "R6", "frame spacing",
                   cyc - last_strobe, m_rate + 1);
            last_strobe = cyc;
            frames_seen++;
         end
         if (bit_clk !== prev_bclk) begin
            if (last_tog >= 0)
               chk(cyc - last_tog == m_bclk + 1, "R7", "bit clock half period",
                   cyc - last_tog, m_bclk + 1);
            last_tog = cyc;
            prev_bclk = bit_clk;
            tog_count++;
         end
         // memory model
         mem_rsp_valid = pend_rsp;
         mem_rsp_data  = pend_data;
         mem_req_ready = (cyc % 3) != 2;
         hs = mem_req_valid && mem_req_ready;
         pend_rsp = hs;
         if (hs) pend_data = memf({8'h0, mem_req_addr});
         // model update for the coming edge
         promote = 0;
         nb = m_bufs.size();
         if (hs && exp_addr.size() > 0) begin
            logic [31:0] a;
            a = exp_addr.pop_front();
            exp_frm.push_back(memf(a));
            m_bufs[0] = m_bufs[0] - 1;
            if (m_bufs[0] == 0) begin
               void'(m_bufs.pop_front());
               if (m_bufs.size() > 0) promote = 1;
            end
         end
         if (reg_we) begin
            case (reg_sel)
               3'd0: m_hold = reg_wdata & 32'h00FF_FFF8;
               3'd1: begin
                  int w;
                  w = (reg_wdata & 32'h0003_FFF8) >> 2;
                  if (w != 0 && nb < 2) begin
                     if (m_bufs.size() == 0) promote = 1;
                     m_bufs.push_back(w);
                     for (int k = 0; k < w; k++) exp_addr.push_back(m_hold + 4 * k);
                  end
               end
               3'd2: begin last_strobe = -1; last_tog = -1; end
               3'd4: m_rate = reg_wdata & 32'h3FFF;
               3'd5: m_bclk = reg_wdata & 32'h1F;
               default: ;
            endcase
         end
         if (promote) m_irq = 1;
         else if (reg_we && reg_sel == 3'd3) m_irq = 0;
      end
   end

   task automatic wr(input int sel, input logic [31:0] d);
      @(posedge clk); #1;
      reg_we = 1; reg_sel = 3'(sel); reg_wdata = d;
      @(posedge clk); #1;
      reg_we = 0;
   endtask

   task automatic rd(input int sel, output logic [31:0] d);
      @(posedge clk); #1;
      reg_sel = 3'(sel);
      #1 d = reg_rdata;
   endtask

   task automatic wait_drain();
      for (int i = 0; i < 4000; i++) begin
         if (m_bufs.size() == 0 && exp_addr.size() == 0 && exp_frm.size() == 0 && !pend_rsp) break;
         @(posedge clk);
      end
      repeat (3 * (m_rate + 1)) @(posedge clk);
   endtask

   task automatic finish_run();
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   endtask

   initial begin
      #(CLK_PERIOD * 100000);
      if (!done) begin
         errors++; checks++;
         $display("FAIL watchdog run did not complete actual=0 expected=1");
         finish_run();
      end
   end

   initial begin
      logic [31:0] v;
      int fs;
      repeat (5) @(posedge clk);
      #1 rst_n = 1;
      @(negedge clk); #1;
      // R1
      chk(irq == 0 && pcm_strobe == 0 && mem_req_valid == 0, "R1", "irq/strobe/req",
          {irq, pcm_strobe, mem_req_valid}, 0);
      chk({pcm_left, pcm_right} == 0, "R1", "pcm outputs", {pcm_left, pcm_right}, 0);
      rd(3, v); chk(v == 0, "R1", "status after reset", v, 0);

      // R11 readback
      wr(4, 1103); rd(4, v); chk(v == 1103, "R11", "rate divider readback", v, 1103);
      wr(5, 15);   rd(5, v); chk(v == 15, "R11", "bit divider readback", v, 15);
      wr(4, 7); wr(5, 2);
      rd(6, v); chk(v == 0, "R11", "unused offset", v, 0);
      wr(0, 32'h0000_1007); rd(0, v); chk(v == 32'h1000, "R2", "address masking", v, 32'h1000);

      // queue fill while disabled
      wr(1, 32'h20);
      rd(1, v); chk(v == 32'h20, "R11", "length readback", v, 32'h20);
      rd(3, v); chk(v == 32'h4000_0001, "R3", "busy with irq after first commit", v, 32'h4000_0001);
      wr(0, 32'h2000); wr(1, 32'h13);
      rd(3, v); chk(v == 32'hC000_0001, "R3", "full after second commit", v, 32'hC000_0001);
      wr(0, 32'h5000); wr(1, 32'h40);
      rd(3, v); chk(v == 32'hC000_0001, "R3", "write while full ignored", v, 32'hC000_0001);
      repeat (20) @(posedge clk);
      #1 chk(mem_req_valid == 0 && frames_seen == 0, "R9", "idle while disabled",
             frames_seen, 0);
      wr(3, 32'hFFFF_FFFF);
      rd(3, v); chk(v == 32'hC000_0000, "R8", "irq cleared by status write", v, 32'hC000_0000);

      // play
      wr(2, 1);
      for (int i = 0; i < 2000 && !irq; i++) @(posedge clk);
      #1 chk(irq == 1, "R8", "irq on promotion of queued buffer", irq, 1);
      wr(0, 32'h6000); wr(1, 32'h4);
      rd(3, v); chk(v[31:30] == 2'b01, "R2", "zero length commit ignored", v[31:30], 1);
      wait_drain();
      rd(3, v); chk(v == 32'h0000_0001, "R10", "busy drops at end", v, 1);
      chk(frames_seen == 12, "R4", "frames from two buffers", frames_seen, 12);
      chk({pcm_left, pcm_right} == memf(32'h200C), "R10", "last frame held",
          {pcm_left, pcm_right}, memf(32'h200C));
      fs = frames_seen;
      repeat (40) @(posedge clk);
      #1 chk(frames_seen == fs && mem_req_valid == 0, "R10", "no activity after end",
             frames_seen, fs);
      chk({pcm_left, pcm_right} == memf(32'h200C), "R10", "frame still held",
          {pcm_left, pcm_right}, memf(32'h200C));

      // pause and resume
      wr(3, 0); wr(0, 32'h3000); wr(1, 32'h40);
      for (int i = 0; i < 2000 && frames_seen < fs + 4; i++) @(posedge clk);
      wr(2, 0);
      @(negedge clk); #1 fs = frames_seen;
      repeat (40) @(posedge clk);
      #1 chk(frames_seen == fs && mem_req_valid == 0, "R9", "paused output", frames_seen, fs);
      rd(3, v); chk(v[30] == 1, "R9", "queue kept while paused", v[30], 1);
      wr(2, 1);
      wait_drain();
      chk(frames_seen == 28, "R9", "all frames after resume", frames_seen, 28);
      chk(exp_frm.size() == 0 && exp_addr.size() == 0, "R4", "nothing left outstanding",
          exp_frm.size() + exp_addr.size(), 0);
      chk(tog_count > 10, "R7", "bit clock active", tog_count, 11);
      done = 1;
      finish_run();
   end

endmodule